// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that announces each bus transfer through a three-bit status code. It converts that code into individual active-low command strobes for memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces an address latch enable pulse and a flag that marks an open bus cycle. The code 111 is the idle (passive) code. A cycle opens when the status leaves 111 and closes when the status returns to 111.

A halt code opens a cycle that drives no command strobe. It also sets a sticky halted indication. A float input signals that another master owns the bus. While float is high the status lines are meaningless, so the decoder ignores them and holds every command inactive.

Top module: `bus_cmd_decoder`

## Requirements
- R1: Reset (rstN low, asynchronous) drives ale, cycleActive and halted to 0 and all five command outputs to 1.
- R2: On a rising edge where the previous sampled code was 111 and the current code is not 111 (with busFloat low), ale is 1 for exactly the next clock and cycleActive rises with it.
- R3: The clock after the ale clock, one command goes low and stays low until the edge that samples 111. The code mapping is: 101 or 100 gives memRdN, 110 gives memWrN, 001 gives ioRdN, 010 gives ioWrN and 000 gives intaN.
- R4: At most one of the five command outputs is low at any time.
- R5: Code 011 opens a cycle with no command. The halted output goes to 1 on the edge that opens that cycle. It returns to 0 on the edge that opens the next cycle with any other non-passive code.
- R6: cycleActive is 1 from the ale clock through the last command clock, and 0 after the edge that samples 111.
- R7: While busFloat is 1, every command is 1 in that same clock. The status is treated as 111 and any open cycle is abandoned at the next edge. When float ends with a non-passive status, a new cycle starts.
- R8: The command is chosen from the code that opened the cycle. A later change to a different non-passive code inside the cycle does not change which strobe is low.
- R9: If the status returns to 111 during the ale clock, the cycle ends with no command asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busStatus | input | 3 | Processor bus status code |
| busFloat | input | 1 | High while another master owns the bus |
| memRdN | output | 1 | Memory read command, active low |
| memWrN | output | 1 | Memory write command, active low |
| ioRdN | output | 1 | I/O read command, active low |
| ioWrN | output | 1 | I/O write command, active low |
| intaN | output | 1 | Interrupt acknowledge, active low |
| ale | output | 1 | One-clock address latch enable pulse |
| cycleActive | output | 1 | A bus cycle is open |
| halted | output | 1 | The last opened cycle was a halt |

## Verification
Some properties are checked on every clock by assertions. These are: the single-clock width of ale and its link to a passive-to-active transition, the exclusivity of the command strobes, the suppression of all commands under float, and the fact that a command only appears inside an open cycle after the ale clock. The bench scenarios cover the rest, because they need knowledge of the whole sequence. That includes the correct code-to-strobe mapping for each code, the set and clear points of the halted flag, the latching of the opening code, the cycle that collapses during ale, and the restart after float ends.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
  localparam int STATUS_W = 3;
  localparam int NUM_CMD  = 5;
  // command slot indices
  localparam int CMD_MEMRD = 0;
  localparam int CMD_MEMWR = 1;
  localparam int CMD_IORD  = 2;
  localparam int CMD_IOWR  = 3;
  localparam int CMD_INTA  = 4;

  typedef enum logic [STATUS_W-1:0] {
    CODE_INTA  = 3'b000,
    CODE_IORD  = 3'b001,
    CODE_IOWR  = 3'b010,
    CODE_HALT  = 3'b011,
    CODE_FETCH = 3'b100,
    CODE_MEMRD = 3'b101,
    CODE_MEMWR = 3'b110,
    CODE_IDLE  = 3'b111
  } busCode_e;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_CMD} phase_e;

  typedef struct packed {
    logic captureCode;
    logic alePhase;
    logic cmdPhase;
    logic busy;
  } ctrlStrobes_t;

  function automatic logic codeHits(input int slot, input logic [STATUS_W-1:0] code);
    case (slot)
      CMD_MEMRD: codeHits = (code == CODE_MEMRD) || (code == CODE_FETCH);
      CMD_MEMWR: codeHits = (code == CODE_MEMWR);
      CMD_IORD:  codeHits = (code == CODE_IORD);
      CMD_IOWR:  codeHits = (code == CODE_IOWR);
      CMD_INTA:  codeHits = (code == CODE_INTA);
      default:   codeHits = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bus_cmd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busFloat,
  input  logic         startSeen,
  input  logic         passiveNow,
  output ctrlStrobes_t strobes
);
  phase_e phaseQ, phaseNext;

  always_comb begin
    phaseNext = phaseQ;
    if (busFloat) begin
      phaseNext = PH_IDLE;
    end else begin
      case (phaseQ)
        PH_IDLE: if (startSeen) phaseNext = PH_ADDR;
        PH_ADDR: phaseNext = passiveNow ? PH_IDLE : PH_CMD;
        PH_CMD:  if (passiveNow) phaseNext = PH_IDLE;
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PH_IDLE;
    else       phaseQ <= phaseNext;
  end

  always_comb begin
    strobes.captureCode = (phaseQ == PH_IDLE) && startSeen && !busFloat;
    strobes.alePhase    = (phaseQ == PH_ADDR);
    strobes.cmdPhase    = (phaseQ == PH_CMD);
    strobes.busy        = (phaseQ != PH_IDLE);
  end
endmodule

// File: rtl/bus_cmd_datapath.sv
module bus_cmd_datapath
  import bus_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] busStatus,
  input  logic                busFloat,
  input  ctrlStrobes_t        strobes,
  output logic                startSeen,
  output logic                passiveNow,
  output logic [NUM_CMD-1:0]  cmdN,
  output logic                halted
);
  logic [STATUS_W-1:0] statusEff;
  logic [STATUS_W-1:0] prevQ;
  logic [STATUS_W-1:0] codeQ;
  logic                haltQ;

  assign statusEff  = busFloat ? CODE_IDLE : busStatus;
  assign passiveNow = (statusEff == CODE_IDLE);
  assign startSeen  = (prevQ == CODE_IDLE) && !passiveNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= CODE_IDLE;
      codeQ <= CODE_IDLE;
      haltQ <= 1'b0;
    end else begin
      prevQ <= statusEff;
      if (strobes.captureCode) begin
        codeQ <= statusEff;
        haltQ <= (statusEff == CODE_HALT);
      end
    end
  end

  for (genvar slot = 0; slot < NUM_CMD; slot++) begin : g_cmd
    assign cmdN[slot] = ~(strobes.cmdPhase && !busFloat && codeHits(slot, codeQ));
  end

  assign halted = haltQ;
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
  import bus_cmd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] busStatus,
  input  logic                busFloat,
  output logic                memRdN,
  output logic                memWrN,
  output logic                ioRdN,
  output logic                ioWrN,
  output logic                intaN,
  output logic                ale,
  output logic                cycleActive,
  output logic                halted
);
  ctrlStrobes_t       strobes;
  logic               startSeen;
  logic               passiveNow;
  logic [NUM_CMD-1:0] cmdN;

  bus_cmd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busFloat(busFloat),
    .startSeen(startSeen), .passiveNow(passiveNow), .strobes(strobes)
  );

  bus_cmd_datapath dp_i (
    .clk(clk), .rstN(rstN), .busStatus(busStatus), .busFloat(busFloat),
    .strobes(strobes), .startSeen(startSeen), .passiveNow(passiveNow),
    .cmdN(cmdN), .halted(halted)
  );

  assign memRdN      = cmdN[CMD_MEMRD];
  assign memWrN      = cmdN[CMD_MEMWR];
  assign ioRdN       = cmdN[CMD_IORD];
  assign ioWrN       = cmdN[CMD_IOWR];
  assign intaN       = cmdN[CMD_INTA];
  assign ale         = strobes.alePhase;
  assign cycleActive = strobes.busy;
endmodule

// File: rtl/bus_cmd_checker.sv
module bus_cmd_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] busStatus,
  input logic       busFloat,
  input logic       memRdN,
  input logic       memWrN,
  input logic       ioRdN,
  input logic       ioWrN,
  input logic       intaN,
  input logic       ale,
  input logic       cycleActive
);
  logic [4:0] lowCmds;
  assign lowCmds = ~{memRdN, memWrN, ioRdN, ioWrN, intaN};

  // R4
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(lowCmds));
  // R2
  ale_width_chk: assert property (@(posedge clk) disable iff (!rstN) ale |=> !ale);
  // R2
  ale_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ale) |-> ($past(busStatus) != 3'b111) && !$past(busFloat));
  // R7
  float_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busFloat |-> (lowCmds == 5'b0));
  // R6
  ale_active_chk: assert property (@(posedge clk) disable iff (!rstN) ale |-> cycleActive);
  // R3
  cmd_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lowCmds != 5'b0) |-> cycleActive && !ale);
endmodule

bind bus_cmd_decoder bus_cmd_checker chk_i (
  .clk(clk), .rstN(rstN), .busStatus(busStatus), .busFloat(busFloat),
  .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
  .intaN(intaN), .ale(ale), .cycleActive(cycleActive)
);

// File: tb/bus_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module bus_cmd_decoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busStatus = 3'b111;
  logic busFloat = 1'b0;
  logic memRdN, memWrN, ioRdN, ioWrN, intaN, ale, cycleActive, halted;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_cmd_decoder dut_i (
    .clk(clk), .rstN(rstN), .busStatus(busStatus), .busFloat(busFloat),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .intaN(intaN), .ale(ale), .cycleActive(cycleActive), .halted(halted)
  );

  // observed bits: {ale, cycleActive, halted, memRdN, memWrN, ioRdN, ioWrN, intaN}
  function automatic logic [7:0] observe();
    return {ale, cycleActive, halted, memRdN, memWrN, ioRdN, ioWrN, intaN};
  endfunction

  task automatic check(input int req, input logic [7:0] expv);
    logic [7:0] act;
    act = observe();
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL R%0d: got %b expected %b", req, act, expv);
    end
  endtask

  // entry: {req tag, status, float, expected outputs after the edge}
  localparam int NVEC = 37;
  localparam logic [15:0] VECS [NVEC] = '{
    {4'd1, 3'b111, 1'b0, 8'b000_11111},  // R1 idle holds
    {4'd2, 3'b101, 1'b0, 8'b110_11111},  // R2 ale on start
    {4'd3, 3'b101, 1'b0, 8'b010_01111},  // R3 memRd
    {4'd3, 3'b101, 1'b0, 8'b010_01111},  // R3 held
    {4'd6, 3'b111, 1'b0, 8'b000_11111},  // R6 end
    {4'd2, 3'b110, 1'b0, 8'b110_11111},  // R2
    {4'd3, 3'b110, 1'b0, 8'b010_10111},  // R3 memWr
    {4'd6, 3'b111, 1'b0, 8'b000_11111},  // R6
    {4'd2, 3'b001, 1'b0, 8'b110_11111},  // R2
    {4'd3, 3'b001, 1'b0, 8'b010_11011},  // R3 ioRd
    {4'd6, 3'b111, 1'b0, 8'b000_11111},  // R6
    {4'd2, 3'b010, 1'b0, 8'b110_11111},  // R2
    {4'd3, 3'b010, 1'b0, 8'b010_11101},  // R3 ioWr
    {4'd6, 3'b111, 1'b0, 8'b000_11111},  // R6
    {4'd2, 3'b000, 1'b0, 8'b110_11111},  // R2
    {4'd3, 3'b000, 1'b0, 8'b010_11110},  // R3 inta
    {4'd6, 3'b111, 1'b0, 8'b000_11111},  // R6
    {4'd2, 3'b100, 1'b0, 8'b110_11111},  // R2
    {4'd3, 3'b100, 1'b0, 8'b010_01111},  // R3 fetch as memRd
    {4'd6, 3'b111, 1'b0, 8'b000_11111},  // R6
    {4'd5, 3'b011, 1'b0, 8'b111_11111},  // R5 halt sets flag
    {4'd5, 3'b011, 1'b0, 8'b011_11111},  // R5 no strobe
    {4'd5, 3'b111, 1'b0, 8'b001_11111},  // R5 flag sticks
    {4'd5, 3'b111, 1'b0, 8'b001_11111},  // R5
    {4'd5, 3'b101, 1'b0, 8'b110_11111},  // R5 clears on new cycle
    {4'd3, 3'b101, 1'b0, 8'b010_01111},  // R3
    {4'd7, 3'b101, 1'b1, 8'b000_11111},  // R7 float abandons
    {4'd7, 3'b000, 1'b1, 8'b000_11111},  // R7 status ignored
    {4'd7, 3'b111, 1'b0, 8'b000_11111},  // R7
    {4'd9, 3'b110, 1'b0, 8'b110_11111},  // R9 start
    {4'd9, 3'b111, 1'b0, 8'b000_11111},  // R9 collapse, no command
    {4'd8, 3'b101, 1'b0, 8'b110_11111},  // R8 open with memRd
    {4'd8, 3'b110, 1'b0, 8'b010_01111},  // R8 code change ignored
    {4'd8, 3'b111, 1'b0, 8'b000_11111},  // R8
    {4'd7, 3'b010, 1'b1, 8'b000_11111},  // R7 floated
    {4'd7, 3'b010, 1'b0, 8'b110_11111},  // R7 restart after float
    {4'd7, 3'b111, 1'b0, 8'b000_11111}   // R7
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    #1;
    check(1, 8'b000_11111);  // R1 during reset
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      busStatus = VECS[i][11:9];
      busFloat  = VECS[i][8];
      @(posedge clk);
      #1;
      check(int'(VECS[i][15:12]), VECS[i][7:0]);
    end

    // R7: float gates an active strobe within the same clock
    @(negedge clk); busStatus = 3'b110;
    @(negedge clk);
    @(negedge clk);
    check(3, 8'b010_10111);
    busFloat = 1'b1;
    #1;
    check(7, 8'b010_11111);
    @(negedge clk); busFloat = 1'b0; busStatus = 3'b111;
    @(negedge clk);
    check(7, 8'b000_11111);

    // R1: reset in the middle of a halt cycle
    busStatus = 3'b011;
    @(negedge clk);
    check(5, 8'b111_11111);
    rstN = 1'b0;
    #1;
    check(1, 8'b000_11111);
    busStatus = 3'b111;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, 8'b000_11111);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule